// File: doc/BRIEF.md
# Base Integer Instruction Field Decoder

This block takes one 32-bit base-integer instruction word and splits it, within the same evaluation and without a clock, into every field that later pipeline logic needs. These fields are the three register indices, the opcode, the two function fields, a one-hot class that names the encoding format, and a 32-bit immediate that is fully assembled and sign-extended. The register indices always sit at the same bit positions, so they are taken straight from the word. The immediate for each of the six formats is built in parallel and then selected by the format class.

The format class comes from the opcode alone. An opcode outside the supported base set raises an illegal flag, clears every class bit and forces the immediate to zero. The block is meant to sit directly after the fetch register of a simple integer core, feeding register-file addresses and the operand multiplexers.

Top module: `instr_field_decoder`

## Requirements
- R1: For every input word, including illegal ones, rd_o equals bits [11:7], rs1_o equals bits [19:15] and rs2_o equals bits [24:20].
- R2: For every input word, opcode_o equals bits [6:0], funct3_o equals bits [14:12] and funct7_o equals bits [31:25].
- R3: fmt_o is one-hot with bit 0 = R, bit 1 = I, bit 2 = S, bit 3 = B, bit 4 = U, bit 5 = J. Opcode 0110011 maps to R. Opcodes 0010011, 0000011, 1100111 and 1110011 map to I. Opcode 0100011 maps to S, 1100011 to B, 0110111 and 0010111 to U, and 1101111 to J.
- R4: Any other opcode sets illegal_o to 1, clears all fmt_o bits and drives imm_o to 0. illegal_o is 0 for every opcode listed in R3.
- R5: For I format, imm_o is bits [31:20] sign-extended from bit 31. An all-ones field gives 0xFFFFFFFF.
- R6: For S format, imm_o is {bits[31:25], bits[11:7]} sign-extended from bit 31.
- R7: For B format, imm_o is {bit31, bit7, bits[30:25], bits[11:8], 0} sign-extended from bit 31, so bit 0 is always 0.
- R8: For J format, imm_o is {bit31, bits[19:12], bit20, bits[30:21], 0} sign-extended from bit 31, so bit 0 is always 0.
- R9: For U format, imm_o[31:12] equals bits [31:12] and imm_o[11:0] is 0.
- R10: For R format, imm_o is 0 whatever the other bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| opcode_o | output | 7 | Major opcode field |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| funct3_o | output | 3 | Minor function field |
| funct7_o | output | 7 | Upper function field |
| fmt_o | output | 6 | One-hot format class (R, I, S, B, U, J from bit 0) |
| imm_o | output | 32 | Assembled, sign-extended immediate |
| illegal_o | output | 1 | Opcode outside the supported set |

## Verification
Random words carrying one of the ten legal opcodes drive every immediate path. Their random upper bits catch a misplaced or swapped immediate piece in S, B and J, and the mixed sign bits separate sign extension from zero extension. Fully random words mostly hit illegal opcodes and confirm that the immediate is forced to zero while the register fields still follow the word. Directed words cover the remaining corners: the all-ones I immediate, negative extremes of B and J, an R word with every other bit set (which must still give a zero immediate), the all-ones illegal word and the all-zero word.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;

  localparam int ILEN   = 32;
  localparam int OPC_W  = 7;
  localparam int RIDX_W = 5;
  localparam int F3_W   = 3;
  localparam int F7_W   = 7;
  localparam int NFMT   = 6;

  // bit positions of the fixed fields
  localparam int RD_LSB  = OPC_W;
  localparam int F3_LSB  = RD_LSB + RIDX_W;
  localparam int RS1_LSB = F3_LSB + F3_W;
  localparam int RS2_LSB = RS1_LSB + RIDX_W;
  localparam int F7_LSB  = RS2_LSB + RIDX_W;

  // one-hot class positions
  localparam int CLS_R = 0;
  localparam int CLS_I = 1;
  localparam int CLS_S = 2;
  localparam int CLS_B = 3;
  localparam int CLS_U = 4;
  localparam int CLS_J = 5;

  typedef logic [OPC_W-1:0] opc_t;
  typedef logic [ILEN-1:0]  word_t;
  typedef logic [NFMT-1:0]  fmt_t;

  localparam opc_t OP_REG_ALU  = 7'b0110011;
  localparam opc_t OP_IMM_ALU  = 7'b0010011;
  localparam opc_t OP_LOAD     = 7'b0000011;
  localparam opc_t OP_JUMP_REG = 7'b1100111;
  localparam opc_t OP_SYSTEM   = 7'b1110011;
  localparam opc_t OP_STORE    = 7'b0100011;
  localparam opc_t OP_BRANCH   = 7'b1100011;
  localparam opc_t OP_UPPER    = 7'b0110111;
  localparam opc_t OP_UPPER_PC = 7'b0010111;
  localparam opc_t OP_JUMP     = 7'b1101111;

  function automatic word_t build_imm_i(input word_t w);
    return {{(ILEN-12){w[31]}}, w[31:20]};
  endfunction

  function automatic word_t build_imm_s(input word_t w);
    return {{(ILEN-12){w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic word_t build_imm_b(input word_t w);
    return {{(ILEN-13){w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  function automatic word_t build_imm_u(input word_t w);
    return {w[31:12], 12'b0};
  endfunction

  function automatic word_t build_imm_j(input word_t w);
    return {{(ILEN-21){w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

endpackage

// File: rtl/instr_reg_fields.sv
module instr_reg_fields
  import instr_dec_pkg::*;
(
  input  logic [ILEN-1:0]   word_i,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [RIDX_W-1:0] rd_o,
  output logic [RIDX_W-1:0] rs1_o,
  output logic [RIDX_W-1:0] rs2_o,
  output logic [F3_W-1:0]   funct3_o,
  output logic [F7_W-1:0]   funct7_o
);

  // fixed positions: no dependence on the format class
  assign opcode_o = word_i[OPC_W-1:0];
  assign rd_o     = word_i[RD_LSB  +: RIDX_W];
  assign funct3_o = word_i[F3_LSB  +: F3_W];
  assign rs1_o    = word_i[RS1_LSB +: RIDX_W];
  assign rs2_o    = word_i[RS2_LSB +: RIDX_W];
  assign funct7_o = word_i[F7_LSB  +: F7_W];

endmodule

// File: rtl/instr_fmt_classify.sv
module instr_fmt_classify
  import instr_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output logic [NFMT-1:0]  fmt_o,
  output logic             illegal_o
);

  always_comb begin
    fmt_o = '0;
    unique case (opcode_i)
      OP_REG_ALU:                              fmt_o[CLS_R] = 1'b1;
      OP_IMM_ALU, OP_LOAD, OP_JUMP_REG,
      OP_SYSTEM:                               fmt_o[CLS_I] = 1'b1;
      OP_STORE:                                fmt_o[CLS_S] = 1'b1;
      OP_BRANCH:                               fmt_o[CLS_B] = 1'b1;
      OP_UPPER, OP_UPPER_PC:                   fmt_o[CLS_U] = 1'b1;
      OP_JUMP:                                 fmt_o[CLS_J] = 1'b1;
      default:                                 fmt_o = '0;
    endcase
  end

  assign illegal_o = ~|fmt_o;

endmodule

// File: rtl/instr_imm_builder.sv
module instr_imm_builder
  import instr_dec_pkg::*;
(
  input  logic [ILEN-1:OPC_W] body_i,
  input  logic [NFMT-1:0]     fmt_i,
  output logic [ILEN-1:0]     imm_o
);

  logic [ILEN-1:0] word;
  logic [ILEN-1:0] cand   [NFMT];
  logic [ILEN-1:0] masked [NFMT];

  assign word = {body_i, {OPC_W{1'b0}}};

  // every candidate built in parallel
  genvar g;
  generate
    for (g = 0; g < NFMT; g++) begin : g_cand
      if (g == CLS_I) begin : g_i
        assign cand[g] = build_imm_i(word);
      end else if (g == CLS_S) begin : g_s
        assign cand[g] = build_imm_s(word);
      end else if (g == CLS_B) begin : g_b
        assign cand[g] = build_imm_b(word);
      end else if (g == CLS_U) begin : g_u
        assign cand[g] = build_imm_u(word);
      end else if (g == CLS_J) begin : g_j
        assign cand[g] = build_imm_j(word);
      end else begin : g_zero
        assign cand[g] = '0;
      end
      assign masked[g] = fmt_i[g] ? cand[g] : '0;
    end
  endgenerate

  // AND-OR select; an empty class vector yields zero
  always_comb begin
    imm_o = '0;
    for (int k = 0; k < NFMT; k++) begin
      imm_o = imm_o | masked[k];
    end
  end

endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
  import instr_dec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [6:0]  opcode_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [2:0]  funct3_o,
  output logic [6:0]  funct7_o,
  output logic [5:0]  fmt_o,
  output logic [31:0] imm_o,
  output logic        illegal_o
);

  // named internal events for the checker
  logic [NFMT-1:0] fmt_sel;
  logic            opc_bad;
  logic [ILEN-1:0] imm_asm;

  instr_reg_fields u_fields (
    .word_i   (instr_i),
    .opcode_o (opcode_o),
    .rd_o     (rd_o),
    .rs1_o    (rs1_o),
    .rs2_o    (rs2_o),
    .funct3_o (funct3_o),
    .funct7_o (funct7_o)
  );

  instr_fmt_classify u_class (
    .opcode_i  (instr_i[OPC_W-1:0]),
    .fmt_o     (fmt_sel),
    .illegal_o (opc_bad)
  );

  instr_imm_builder u_imm (
    .body_i (instr_i[ILEN-1:OPC_W]),
    .fmt_i  (fmt_sel),
    .imm_o  (imm_asm)
  );

  assign fmt_o     = fmt_sel;
  assign illegal_o = opc_bad;
  assign imm_o     = imm_asm;

endmodule

// File: rtl/instr_field_decoder_chk.sv
module instr_field_decoder_chk
  import instr_dec_pkg::*;
(
  input logic            sign_i,
  input logic [NFMT-1:0] fmt_i,
  input logic            illegal_i,
  input logic [ILEN-1:0] imm_i
);

  always_comb begin
    // R3
    fmt_onehot_chk: assert ($onehot0(fmt_i))
      else $error("format class not one-hot");
    // R4
    illegal_cls_chk: assert (illegal_i == ($countones(fmt_i) == 0))
      else $error("illegal flag disagrees with class");
    // R4
    illegal_imm_chk: assert (!illegal_i || imm_i == '0)
      else $error("illegal word gave nonzero immediate");
    // R10
    rfmt_imm_chk: assert (!fmt_i[CLS_R] || imm_i == '0)
      else $error("R class gave nonzero immediate");
    // R9
    ufmt_low_chk: assert (!fmt_i[CLS_U] || imm_i[11:0] == '0)
      else $error("U class low bits not zero");
    // R7
    bfmt_even_chk: assert (!fmt_i[CLS_B] || !imm_i[0])
      else $error("B class offset odd");
    // R8
    jfmt_even_chk: assert (!fmt_i[CLS_J] || !imm_i[0])
      else $error("J class offset odd");
    // R5
    sign_ext_chk: assert (!(fmt_i[CLS_I] | fmt_i[CLS_S] | fmt_i[CLS_B] | fmt_i[CLS_J])
                          || imm_i[ILEN-1] == sign_i)
      else $error("immediate sign does not follow bit 31");
  end

endmodule

bind instr_field_decoder instr_field_decoder_chk u_chk (
  .sign_i    (instr_i[31]),
  .fmt_i     (fmt_sel),
  .illegal_i (opc_bad),
  .imm_i     (imm_asm)
);

// File: tb/instr_field_decoder_test.sv
module instr_field_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic        clk = 1'b0;
  logic [31:0] instr;
  logic [6:0]  opcode;
  logic [4:0]  rd, rs1, rs2;
  logic [2:0]  f3;
  logic [6:0]  f7;
  logic [5:0]  fmt;
  logic [31:0] imm;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_field_decoder uut (
    .instr_i   (instr),
    .opcode_o  (opcode),
    .rd_o      (rd),
    .rs1_o     (rs1),
    .rs2_o     (rs2),
    .funct3_o  (f3),
    .funct7_o  (f7),
    .fmt_o     (fmt),
    .imm_o     (imm),
    .illegal_o (illegal)
  );

  // expected class index per R3; -1 for illegal (R4)
  function automatic int exp_cls(input logic [6:0] op);
    case (op)
      7'b0110011: return 0;
      7'b0010011, 7'b0000011, 7'b1100111, 7'b1110011: return 1;
      7'b0100011: return 2;
      7'b1100011: return 3;
      7'b0110111, 7'b0010111: return 4;
      7'b1101111: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_imm(input logic [31:0] w);
    case (exp_cls(w[6:0]))
      1: return 32'($signed(w[31:20]));
      2: return 32'($signed({w[31:25], w[11:7]}));
      3: return 32'($signed({w[31], w[7], w[30:25], w[11:8], 1'b0}));
      4: return w & 32'hFFFF_F000;
      5: return 32'($signed({w[31], w[19:12], w[20], w[30:21], 1'b0}));
      default: return 32'h0;
    endcase
  endfunction

  function automatic string imm_req(input logic [31:0] w);
    case (exp_cls(w[6:0]))
      0: return "R10";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R9";
      5: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s word=%08h actual=%08h expected=%08h", req, instr, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    int c;
    logic [5:0] efmt;
    @(posedge clk);
    instr = w;
    @(negedge clk);
    c = exp_cls(w[6:0]);
    efmt = (c < 0) ? 6'b0 : 6'(1 << c);
    // R1
    chk("R1", {27'b0, rd},  {27'b0, w[11:7]});
    chk("R1", {27'b0, rs1}, {27'b0, w[19:15]});
    chk("R1", {27'b0, rs2}, {27'b0, w[24:20]});
    // R2
    chk("R2", {25'b0, opcode}, {25'b0, w[6:0]});
    chk("R2", {29'b0, f3},     {29'b0, w[14:12]});
    chk("R2", {25'b0, f7},     {25'b0, w[31:25]});
    // R3
    chk("R3", {26'b0, fmt}, {26'b0, efmt});
    // R4
    chk("R4", {31'b0, illegal}, {31'b0, (c < 0)});
    chk(imm_req(w), imm, exp_imm(w));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [6:0] legal [10];
    int unsigned seed;
    legal = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b1100111, 7'b1110011,
              7'b0100011, 7'b1100011, 7'b0110111, 7'b0010111, 7'b1101111};
    seed = $urandom(32'd20240611);
    instr = 32'h0;

    // zero word: illegal opcode, zero immediate (R4)
    apply(32'h0000_0000);
    // I immediate all ones -> 0xFFFFFFFF (R5)
    apply(32'hFFF0_0013);
    // I positive maximum (R5)
    apply(32'h7FF0_0003);
    // R word with all other bits set: immediate stays zero (R10)
    apply(32'hFFFF_FFB3);
    // all ones: illegal opcode (R4)
    apply(32'hFFFF_FFFF);
    // S negative extreme (R6)
    apply(32'hFE00_0FA3);
    // B negative extreme and smallest positive (R7)
    apply(32'hFE00_0FE3);
    apply(32'h0000_0163);
    // J negative extreme and single bit 20 (R8)
    apply(32'hFFFF_F06F);
    apply(32'h0010_006F);
    // U with low garbage (R9)
    apply(32'hABCD_EFB7);
    apply(32'h8000_0F97);

    for (int n = 0; n < N_RAND; n++) begin
      logic [31:0] w;
      w = $urandom;
      if (($urandom % 5) != 0) w[6:0] = legal[$urandom % 10];
      apply(w);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule